// File: doc/BRIEF.md
# Dataflow Operand-Matching Processing Element

This block is one processing element of a dataflow machine. It has no program counter and fetches nothing in sequence. It holds a few configured instructions, called slots, and collects the operand tokens that arrive for them. Each token names a target slot, an operand position (0 or 1) and a wave number. Tokens are paired only when their slot and their wave number both agree. A slot executes as soon as every operand it needs for one wave is present. The result then leaves on point-to-point output ports, one port for each configured consumer, and carries the wave of the operands that produced it.

A wave-advance opcode copies its operand and adds one to the wave tag, which starts the next iteration of a loop. Software or a loader fills the slots through a simple write port. Pending operands wait in an 8-entry matching table. When the table has no free entry, the input stops accepting tokens. Each output port uses a valid/ready handshake, and a port that is occupied makes the element wait.

Top module: `dataflow_pe`

## Requirements
- R1: After reset, `in_ready` is 1, both `out_valid` bits are 0 and the matching table holds no operands.
- R2: A cycle with `cfg_we` high writes the addressed slot. The fields are: opcode `cfg_op` (0 add, 1 subtract, 2 and, 3 or, 4 wave-advance, 5 pass); `cfg_two` (1 means two operands, 0 means operand 0 only); and, for each consumer k, an enable `cfg_dst_en[k]`, an address `cfg_dst_addr[k]` and an operand position `cfg_dst_opnd[k]`.
- R3: A slot fires only when it holds operand 0, and also operand 1 if `cfg_two` is 1, all with one and the same wave number. Operands of different waves never combine.
- R4: Results are computed modulo 2^DATA_W: add gives a+b, subtract gives a-b (a is operand 0), and gives a&b, or gives a|b, pass gives a. For a one-operand slot, b is taken as 0.
- R5: The result carries the wave of its operands. Wave-advance outputs operand 0 unchanged with the wave plus one, wrapping modulo 2^WAVE_W.
- R6: Consumer k of the fired slot is delivered on output port k, with its configured address and operand position. A disabled consumer leaves its port idle. Ports loaded by the same firing carry the same data and wave.
- R7: At most one slot fires per cycle. When several are ready, the lowest slot index fires first. Among waves of one slot, the lowest table entry fires first.
- R8: The table has 8 entries. While all are in use, `in_ready` is 0 and an offered token is neither taken nor has any effect.
- R9: While `out_valid[k]` is 1 and `out_ready[k]` is 0, port k holds its token unchanged. A ready slot that needs that port waits. When the port drains, the next firing can load it in the same cycle.
- R10: When the ports are free, a token that completes a slot and is accepted at clock edge E makes the result visible just after edge E+1.
- R11: A token whose slot and wave match a held entry fills that entry. Otherwise it takes the lowest free entry. Operands may arrive in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_slot | input | SLOT_W | Slot to configure |
| cfg_op | input | 3 | Opcode |
| cfg_two | input | 1 | 1 means two operands |
| cfg_dst_en | input | 2 | Consumer enables |
| cfg_dst_addr | input | 2 x DST_W | Consumer addresses |
| cfg_dst_opnd | input | 2 | Consumer operand positions |
| in_valid | input | 1 | Input token valid |
| in_ready | output | 1 | Input token accepted |
| in_slot | input | SLOT_W | Target slot of the token |
| in_opnd | input | 1 | Operand position of the token |
| in_wave | input | WAVE_W | Wave number of the token |
| in_data | input | DATA_W | Operand value |
| out_valid | output | 2 | Result token valid, one bit per port |
| out_ready | input | 2 | Consumer ready, one bit per port |
| out_addr | output | 2 x DST_W | Consumer address |
| out_opnd | output | 2 | Consumer operand position |
| out_wave | output | 2 x WAVE_W | Result wave |
| out_data | output | 2 x DATA_W | Result value |

## Verification
Two things can happen in the same cycle: an output port drains, and the next firing reloads that port. The bench provokes this by holding `out_ready` low while two slots become ready behind an occupied port. It then raises `out_ready` and expects the lower slot's result in the very next cycle and the other slot's result in the cycle after. A second pair of same-cycle events is a token arriving while another entry fires. The bench judges this through ordering: operands for one slot arrive in mixed wave order, and each result must match its own wave exactly.

// File: rtl/pe_pkg.sv
package pe_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_WADV = 3'd4,
        OP_PASS = 3'd5
    } pe_op_e;

    localparam int NUM_DST  = 2;
    localparam int NUM_OPND = 2;
endpackage

// File: rtl/pe_cfg_store.sv
module pe_cfg_store
    import pe_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int DST_W = 6,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [SLOT_W-1:0]                cfg_slot,
    input  logic [2:0]                       cfg_op,
    input  logic                             cfg_two,
    input  logic [NUM_DST-1:0]               cfg_dst_en,
    input  logic [NUM_DST-1:0][DST_W-1:0]    cfg_dst_addr,
    input  logic [NUM_DST-1:0]               cfg_dst_opnd,
    output logic [SLOTS-1:0]                 slot_two,
    input  logic [SLOT_W-1:0]                rd_slot,
    output pe_op_e                           rd_op,
    output logic                             rd_two,
    output logic [NUM_DST-1:0]               rd_dst_en,
    output logic [NUM_DST-1:0][DST_W-1:0]    rd_dst_addr,
    output logic [NUM_DST-1:0]               rd_dst_opnd
);
    typedef struct packed {
        pe_op_e                          op;
        logic                            two;
        logic [NUM_DST-1:0]              dst_en;
        logic [NUM_DST-1:0][DST_W-1:0]   dst_addr;
        logic [NUM_DST-1:0]              dst_opnd;
    } slot_cfg_t;

    typedef struct packed {
        slot_cfg_t [SLOTS-1:0] slot;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.slot[cfg_slot].op       = pe_op_e'(cfg_op);
            st_d.slot[cfg_slot].two      = cfg_two;
            st_d.slot[cfg_slot].dst_en   = cfg_dst_en;
            st_d.slot[cfg_slot].dst_addr = cfg_dst_addr;
            st_d.slot[cfg_slot].dst_opnd = cfg_dst_opnd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_two
        assign slot_two[s] = st_q.slot[s].two;
    end

    assign rd_op       = st_q.slot[rd_slot].op;
    assign rd_two      = st_q.slot[rd_slot].two;
    assign rd_dst_en   = st_q.slot[rd_slot].dst_en;
    assign rd_dst_addr = st_q.slot[rd_slot].dst_addr;
    assign rd_dst_opnd = st_q.slot[rd_slot].dst_opnd;
endmodule

// File: rtl/pe_match_table.sv
module pe_match_table
    import pe_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SLOTS  = 4,
    parameter int DATA_W = 16,
    parameter int WAVE_W = 8,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tok_valid,
    output logic                 tok_ready,
    input  logic [SLOT_W-1:0]    tok_slot,
    input  logic                 tok_opnd,
    input  logic [WAVE_W-1:0]    tok_wave,
    input  logic [DATA_W-1:0]    tok_data,
    input  logic [SLOTS-1:0]     slot_two,
    input  logic                 fire_i,
    output logic                 sel_valid,
    output logic [SLOT_W-1:0]    sel_slot,
    output logic [WAVE_W-1:0]    sel_wave,
    output logic [DATA_W-1:0]    sel_a,
    output logic [DATA_W-1:0]    sel_b,
    output logic [DEPTH-1:0]     ent_busy
);
    typedef struct packed {
        logic                               vld;
        logic [SLOT_W-1:0]                  slot;
        logic [WAVE_W-1:0]                  wave;
        logic [NUM_OPND-1:0]                have;
        logic [NUM_OPND-1:0][DATA_W-1:0]    opnd;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    logic [DEPTH-1:0] rdy;
    logic             found;
    logic [IDX_W-1:0] sel_idx;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] tgt;

    // readiness of each entry against its slot's operand count
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rdy[i] = st_q.ent[i].vld && st_q.ent[i].have[0] &&
                     (!slot_two[st_q.ent[i].slot] || st_q.ent[i].have[1]);
        end
    end

    // fire selection: slot index first, entry index second
    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        for (int s = 0; s < SLOTS; s++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!found && rdy[i] && (st_q.ent[i].slot == SLOT_W'(s))) begin
                    found   = 1'b1;
                    sel_idx = IDX_W'(i);
                end
            end
        end
    end

    // tag search and free-entry search
    always_comb begin
        hit        = 1'b0;
        hit_idx    = '0;
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit && st_q.ent[i].vld &&
                st_q.ent[i].slot == tok_slot && st_q.ent[i].wave == tok_wave &&
                !(fire_i && sel_idx == IDX_W'(i))) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!free_found && !st_q.ent[i].vld) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign tok_ready = free_found;
    assign tgt       = hit ? hit_idx : free_idx;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            st_d.ent[sel_idx].vld  = 1'b0;
            st_d.ent[sel_idx].have = '0;
        end
        if (tok_valid && tok_ready) begin
            if (!hit) begin
                st_d.ent[tgt].vld  = 1'b1;
                st_d.ent[tgt].slot = tok_slot;
                st_d.ent[tgt].wave = tok_wave;
                st_d.ent[tgt].have = '0;
            end
            st_d.ent[tgt].have[tok_opnd] = 1'b1;
            st_d.ent[tgt].opnd[tok_opnd] = tok_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_valid = found;
    assign sel_slot  = st_q.ent[sel_idx].slot;
    assign sel_wave  = st_q.ent[sel_idx].wave;
    assign sel_a     = st_q.ent[sel_idx].opnd[0];
    assign sel_b     = st_q.ent[sel_idx].opnd[1];

    for (genvar i = 0; i < DEPTH; i++) begin : g_busy
        assign ent_busy[i] = st_q.ent[i].vld;
    end
endmodule

// File: rtl/pe_alu.sv
module pe_alu
    import pe_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WAVE_W = 8
) (
    input  pe_op_e             op,
    input  logic               two,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [WAVE_W-1:0]  wave_in,
    output logic [DATA_W-1:0]  res,
    output logic [WAVE_W-1:0]  wave_out
);
    logic [DATA_W-1:0] b_eff;

    always_comb begin
        b_eff    = two ? b : '0;
        wave_out = wave_in;
        unique case (op)
            OP_ADD:  res = a + b_eff;
            OP_SUB:  res = a - b_eff;
            OP_AND:  res = a & b_eff;
            OP_OR:   res = a | b_eff;
            OP_WADV: begin
                res      = a;
                wave_out = wave_in + WAVE_W'(1);
            end
            default: res = a;
        endcase
    end
endmodule

// File: rtl/pe_out_port.sv
module pe_out_port #(
    parameter int DST_W  = 6,
    parameter int DATA_W = 16,
    parameter int WAVE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DST_W-1:0]   ld_addr,
    input  logic               ld_opnd,
    input  logic [WAVE_W-1:0]  ld_wave,
    input  logic [DATA_W-1:0]  ld_data,
    input  logic               ready,
    output logic               valid,
    output logic [DST_W-1:0]   addr,
    output logic               opnd,
    output logic [WAVE_W-1:0]  wave,
    output logic [DATA_W-1:0]  data,
    output logic               free
);
    typedef struct packed {
        logic               vld;
        logic [DST_W-1:0]   addr;
        logic               opnd;
        logic [WAVE_W-1:0]  wave;
        logic [DATA_W-1:0]  data;
    } port_state_t;

    port_state_t st_d, st_q;

    assign free = !st_q.vld || ready;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.vld  = 1'b1;
            st_d.addr = ld_addr;
            st_d.opnd = ld_opnd;
            st_d.wave = ld_wave;
            st_d.data = ld_data;
        end else if (ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.vld;
    assign addr  = st_q.addr;
    assign opnd  = st_q.opnd;
    assign wave  = st_q.wave;
    assign data  = st_q.data;
endmodule

// File: rtl/dataflow_pe.sv
module dataflow_pe
    import pe_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int WAVE_W = 8,
    parameter int DST_W  = 6,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [SLOT_W-1:0]               cfg_slot,
    input  logic [2:0]                      cfg_op,
    input  logic                            cfg_two,
    input  logic [NUM_DST-1:0]              cfg_dst_en,
    input  logic [NUM_DST-1:0][DST_W-1:0]   cfg_dst_addr,
    input  logic [NUM_DST-1:0]              cfg_dst_opnd,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [SLOT_W-1:0]               in_slot,
    input  logic                            in_opnd,
    input  logic [WAVE_W-1:0]               in_wave,
    input  logic [DATA_W-1:0]               in_data,
    output logic [NUM_DST-1:0]              out_valid,
    input  logic [NUM_DST-1:0]              out_ready,
    output logic [NUM_DST-1:0][DST_W-1:0]   out_addr,
    output logic [NUM_DST-1:0]              out_opnd,
    output logic [NUM_DST-1:0][WAVE_W-1:0]  out_wave,
    output logic [NUM_DST-1:0][DATA_W-1:0]  out_data
);
    logic [SLOTS-1:0]               slot_two;
    pe_op_e                         rd_op;
    logic                           rd_two;
    logic [NUM_DST-1:0]             rd_dst_en;
    logic [NUM_DST-1:0][DST_W-1:0]  rd_dst_addr;
    logic [NUM_DST-1:0]             rd_dst_opnd;

    logic                           sel_valid;
    logic [SLOT_W-1:0]              sel_slot;
    logic [WAVE_W-1:0]              sel_wave;
    logic [DATA_W-1:0]              sel_a, sel_b;
    logic [DEPTH-1:0]               ent_busy;

    logic [DATA_W-1:0]              res_data;
    logic [WAVE_W-1:0]              res_wave;
    logic [NUM_DST-1:0]             port_free;
    logic                           ports_ok;
    logic                           fire;

    pe_cfg_store #(.SLOTS(SLOTS), .DST_W(DST_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_slot     (cfg_slot),
        .cfg_op       (cfg_op),
        .cfg_two      (cfg_two),
        .cfg_dst_en   (cfg_dst_en),
        .cfg_dst_addr (cfg_dst_addr),
        .cfg_dst_opnd (cfg_dst_opnd),
        .slot_two     (slot_two),
        .rd_slot      (sel_slot),
        .rd_op        (rd_op),
        .rd_two       (rd_two),
        .rd_dst_en    (rd_dst_en),
        .rd_dst_addr  (rd_dst_addr),
        .rd_dst_opnd  (rd_dst_opnd)
    );

    pe_match_table #(
        .DEPTH(DEPTH), .SLOTS(SLOTS), .DATA_W(DATA_W), .WAVE_W(WAVE_W)
    ) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (in_valid),
        .tok_ready (in_ready),
        .tok_slot  (in_slot),
        .tok_opnd  (in_opnd),
        .tok_wave  (in_wave),
        .tok_data  (in_data),
        .slot_two  (slot_two),
        .fire_i    (fire),
        .sel_valid (sel_valid),
        .sel_slot  (sel_slot),
        .sel_wave  (sel_wave),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .ent_busy  (ent_busy)
    );

    pe_alu #(.DATA_W(DATA_W), .WAVE_W(WAVE_W)) u_alu (
        .op       (rd_op),
        .two      (rd_two),
        .a        (sel_a),
        .b        (sel_b),
        .wave_in  (sel_wave),
        .res      (res_data),
        .wave_out (res_wave)
    );

    // in-order issue: the head candidate waits until every port it needs is free
    assign ports_ok = &(~rd_dst_en | port_free);
    assign fire     = sel_valid && ports_ok;

    for (genvar k = 0; k < NUM_DST; k++) begin : g_port
        pe_out_port #(.DST_W(DST_W), .DATA_W(DATA_W), .WAVE_W(WAVE_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (fire && rd_dst_en[k]),
            .ld_addr (rd_dst_addr[k]),
            .ld_opnd (rd_dst_opnd[k]),
            .ld_wave (res_wave),
            .ld_data (res_data),
            .ready   (out_ready[k]),
            .valid   (out_valid[k]),
            .addr    (out_addr[k]),
            .opnd    (out_opnd[k]),
            .wave    (out_wave[k]),
            .data    (out_data[k]),
            .free    (port_free[k])
        );
    end
endmodule

// File: rtl/pe_checker.sv
module pe_checker
    import pe_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int WAVE_W = 8,
    parameter int DST_W  = 6
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            in_valid,
    input logic                            in_ready,
    input logic [NUM_DST-1:0]              out_valid,
    input logic [NUM_DST-1:0]              out_ready,
    input logic [NUM_DST-1:0][DST_W-1:0]   out_addr,
    input logic [NUM_DST-1:0]              out_opnd,
    input logic [NUM_DST-1:0][WAVE_W-1:0]  out_wave,
    input logic [NUM_DST-1:0][DATA_W-1:0]  out_data,
    input logic [DEPTH-1:0]                ent_busy
);
    for (genvar k = 0; k < NUM_DST; k++) begin : g_hold
        // R9: a stalled port keeps its token
        p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] && !out_ready[k] |=> out_valid[k] && $stable(out_data[k]) &&
            $stable(out_wave[k]) && $stable(out_addr[k]) && $stable(out_opnd[k]))
            else $error("p_hold_stable_r9 port %0d", k);
    end

    // R6: ports loaded together carry one result
    p_same_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid[0]) && $rose(out_valid[1]) |->
        out_data[0] == out_data[1] && out_wave[0] == out_wave[1])
        else $error("p_same_result_r6");

    // R7: at most one entry is released per cycle
    p_single_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ent_busy) + 1 >= $countones($past(ent_busy)))
        else $error("p_single_issue_r7");

    // R11: an accepted token always leaves an occupied entry behind
    p_accept_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> |ent_busy)
        else $error("p_accept_holds_r11");

    // R8: a completely full table refuses input
    p_full_refuses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&ent_busy) && &ent_busy |-> !in_ready)
        else $error("p_full_refuses_r8");
endmodule

bind dataflow_pe pe_checker #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .WAVE_W(WAVE_W), .DST_W(DST_W)
) u_pe_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_opnd  (out_opnd),
    .out_wave  (out_wave),
    .out_data  (out_data),
    .ent_busy  (ent_busy)
);

// File: tb/tb_dataflow_pe.sv
module tb_dataflow_pe;
    localparam int DATA_W = 16;
    localparam int WAVE_W = 8;
    localparam int DST_W  = 6;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    cfg_we;
    logic [1:0]              cfg_slot;
    logic [2:0]              cfg_op;
    logic                    cfg_two;
    logic [1:0]              cfg_dst_en;
    logic [1:0][DST_W-1:0]   cfg_dst_addr;
    logic [1:0]              cfg_dst_opnd;
    logic                    in_valid;
    logic                    in_ready;
    logic [1:0]              in_slot;
    logic                    in_opnd;
    logic [WAVE_W-1:0]       in_wave;
    logic [DATA_W-1:0]       in_data;
    logic [1:0]              out_valid;
    logic [1:0]              out_ready;
    logic [1:0][DST_W-1:0]   out_addr;
    logic [1:0]              out_opnd;
    logic [1:0][WAVE_W-1:0]  out_wave;
    logic [1:0][DATA_W-1:0]  out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dataflow_pe dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_op(cfg_op), .cfg_two(cfg_two), .cfg_dst_en(cfg_dst_en),
        .cfg_dst_addr(cfg_dst_addr), .cfg_dst_opnd(cfg_dst_opnd),
        .in_valid(in_valid), .in_ready(in_ready), .in_slot(in_slot),
        .in_opnd(in_opnd), .in_wave(in_wave), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_opnd(out_opnd), .out_wave(out_wave), .out_data(out_data)
    );

    typedef struct packed {
        logic [2:0]         op;
        logic               two;
        logic [DATA_W-1:0]  a;
        logic [DATA_W-1:0]  b;
        logic [WAVE_W-1:0]  wave;
        logic [DATA_W-1:0]  exp_data;
        logic [WAVE_W-1:0]  exp_wave;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 1'b1, 16'h1234, 16'h0F0F, 8'd5,   16'h2143, 8'd5},
        '{3'd1, 1'b1, 16'h0005, 16'h0007, 8'd9,   16'hFFFE, 8'd9},
        '{3'd2, 1'b1, 16'hF0F0, 16'h3C3C, 8'd1,   16'h3030, 8'd1},
        '{3'd3, 1'b1, 16'hF000, 16'h000F, 8'd2,   16'hF00F, 8'd2},
        '{3'd5, 1'b0, 16'hBEEF, 16'h0000, 8'd7,   16'hBEEF, 8'd7},
        '{3'd4, 1'b0, 16'h0042, 16'h0000, 8'd10,  16'h0042, 8'd11},
        '{3'd4, 1'b0, 16'h1111, 16'h0000, 8'd255, 16'h1111, 8'd0},
        '{3'd0, 1'b1, 16'hFFFF, 16'h0002, 8'd0,   16'h0001, 8'd0}
    };

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic configure(input logic [1:0] slot, input logic [2:0] op, input logic two,
                             input logic [1:0] en, input logic [DST_W-1:0] a0,
                             input logic o0, input logic [DST_W-1:0] a1, input logic o1);
        @(negedge clk);
        cfg_we       = 1'b1;
        cfg_slot     = slot;
        cfg_op       = op;
        cfg_two      = two;
        cfg_dst_en   = en;
        cfg_dst_addr = {a1, a0};
        cfg_dst_opnd = {o1, o0};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // returns at the negedge after the accepting edge
    task automatic send(input logic [1:0] slot, input logic opnd,
                        input logic [WAVE_W-1:0] wave, input logic [DATA_W-1:0] data);
        @(negedge clk);
        in_valid = 1'b1;
        in_slot  = slot;
        in_opnd  = opnd;
        in_wave  = wave;
        in_data  = data;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_out0(input int limit, output bit seen);
        seen = 1'b0;
        for (int c = 0; c < limit; c++) begin
            if (out_valid[0]) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit seen;
        rst_n = 1'b0;
        cfg_we = 1'b0; cfg_slot = '0; cfg_op = '0; cfg_two = 1'b0;
        cfg_dst_en = '0; cfg_dst_addr = '0; cfg_dst_opnd = '0;
        in_valid = 1'b0; in_slot = '0; in_opnd = 1'b0; in_wave = '0; in_data = '0;
        out_ready = 2'b11;
        do_reset();

        // R1: reset state
        chk("R1", "in_ready", in_ready, 1);
        chk("R1", "out_valid", out_valid, 0);

        // vector table: R2 R4 R5 R6 R11
        foreach (VECS[v]) begin
            configure(2'd0, VECS[v].op, VECS[v].two, 2'b11, 6'h15, 1'b1, 6'h2A, 1'b0);
            send(2'd0, 1'b0, VECS[v].wave, VECS[v].a);
            if (VECS[v].two) send(2'd0, 1'b1, VECS[v].wave, VECS[v].b);
            wait_out0(10, seen);
            chk("R3", "result seen", seen, 1);
            chk("R4", "port0 data", out_data[0], VECS[v].exp_data);
            chk("R5", "port0 wave", out_wave[0], VECS[v].exp_wave);
            chk("R6", "port1 valid", out_valid[1], 1);
            chk("R6", "port1 data", out_data[1], VECS[v].exp_data);
            chk("R2", "port0 addr", out_addr[0], 6'h15);
            chk("R2", "port0 opnd", out_opnd[0], 1);
            chk("R2", "port1 addr", out_addr[1], 6'h2A);
            chk("R2", "port1 opnd", out_opnd[1], 0);
            @(negedge clk);
        end

        // R10 latency and R6 disabled consumer
        configure(2'd1, 3'd5, 1'b0, 2'b01, 6'h03, 1'b0, 6'h00, 1'b0);
        send(2'd1, 1'b0, 8'd3, 16'h00AA);
        chk("R10", "valid one edge after accept", out_valid[0], 0);
        @(negedge clk);
        chk("R10", "valid two edges after accept", out_valid[0], 1);
        chk("R10", "data", out_data[0], 16'h00AA);
        chk("R6", "disabled port idle", out_valid[1], 0);
        @(negedge clk);
        chk("R9", "drained with ready high", out_valid[0], 0);

        // R3 R11 wave matching, operand 1 first
        configure(2'd2, 3'd0, 1'b1, 2'b01, 6'h07, 1'b0, 6'h00, 1'b0);
        send(2'd2, 1'b1, 8'd4, 16'd10);
        send(2'd2, 1'b0, 8'd3, 16'd1);
        wait_out0(6, seen);
        chk("R3", "mismatched waves do not fire", seen, 0);
        send(2'd2, 1'b1, 8'd3, 16'd20);
        wait_out0(6, seen);
        chk("R3", "wave 3 fires", seen, 1);
        chk("R3", "wave 3 sum", out_data[0], 16'd21);
        chk("R5", "wave 3 tag", out_wave[0], 8'd3);
        @(negedge clk);
        send(2'd2, 1'b0, 8'd4, 16'd5);
        wait_out0(6, seen);
        chk("R11", "wave 4 sum", out_data[0], 16'd15);
        chk("R11", "wave 4 tag", out_wave[0], 8'd4);
        @(negedge clk);

        // R7 R9 priority behind a stalled port
        configure(2'd3, 3'd5, 1'b0, 2'b01, 6'h09, 1'b0, 6'h00, 1'b0);
        out_ready = 2'b10;
        send(2'd3, 1'b0, 8'd0, 16'h0033);
        @(negedge clk);
        chk("R9", "stalled port loaded", out_valid[0], 1);
        send(2'd3, 1'b0, 8'd1, 16'h0034);
        send(2'd1, 1'b0, 8'd0, 16'h0011);
        repeat (3) @(negedge clk);
        chk("R9", "held valid", out_valid[0], 1);
        chk("R9", "held data", out_data[0], 16'h0033);
        out_ready = 2'b11;
        @(negedge clk);
        chk("R7", "lowest slot first", out_data[0], 16'h0011);
        chk("R9", "reload in drain cycle", out_valid[0], 1);
        @(negedge clk);
        chk("R7", "higher slot next", out_data[0], 16'h0034);
        @(negedge clk);

        // R8 full table back-pressure
        for (int w = 0; w < 8; w++) send(2'd2, 1'b0, WAVE_W'(10 + w), 16'(w));
        chk("R8", "in_ready low when full", in_ready, 0);
        @(negedge clk);
        in_valid = 1'b1; in_slot = 2'd2; in_opnd = 1'b1; in_wave = 8'd10; in_data = 16'd1;
        seen = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (out_valid[0] || in_ready) seen = 1'b1;
        end
        chk("R8", "offered token ignored", seen, 0);
        in_valid = 1'b0;

        do_reset();
        chk("R1", "in_ready after reset", in_ready, 1);
        chk("R1", "out_valid after reset", out_valid, 0);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule